// File: doc/BRIEF.md
# Hint-Steered Two-Thread Issue Arbiter

This block hands one shared issue slot per cycle to one of two hardware threads. Plain operation is round-robin between the threads that request. Performance hints that retire from a thread change the arbitration only. They never change architectural state.

A qualified hint of value zero parks its thread. A parked thread yields contested slots to its sibling. It leaves the parked state when the sibling stores to the 8-byte block named by the parked thread's last monitored-address load. A hint of value one gives its thread a boost. The boost lasts a fixed number of cycles, and a cooldown of equal length follows in which the thread cannot be boosted again. All other hint values do nothing.

Each thread has its own state machine with four states:
- `TS_RUN` (normal)
- `TS_PARK` (paused)
- `TS_BOOST` (boosted)
- `TS_COOL` (cooldown)

The transitions are:
- **RUN→PARK**: on a pause hint.
- **RUN→BOOST**: on a priority hint.
- **BOOST→COOL**: when the boost count runs out.
- **COOL→RUN**: when the cooldown count runs out.
- **BOOST→PARK** and **COOL→PARK**: on a pause hint.
- **PARK→RUN**: on a waking store.

A parked thread that still requests is granted once every `FLOOR_LEN` cycles. This keeps it from deadlocking when no waking store ever arrives.

Top module: `hint_prio_arb`

## Requirements
- R1: After reset both threads are in `TS_RUN`. Each thread's state appears on `thr_state`, 2 bits per thread, with thread t at bits [2t+1:2t]. The codes are RUN=0, PARK=1, BOOST=2, COOL=3. The first contested grant after reset goes to thread 0.
- R2: `gnt` is one-hot or zero (bit t is thread t). A thread is granted only if its `req` bit is set. Whenever any thread requests, exactly one thread is granted.
- R3: When both threads request and share the same class (neither boosted, parked nor due), grants alternate between the two threads cycle by cycle.
- R4: A hint with its qualifying bit clear has no effect on state. A qualified hint of any value other than 0 or 1 also has no effect on state.
- R5: The hint value for a thread depends on its `hint_wide` bit.
  - When `hint_wide` is set, the value is {`hint_hi`, `hint_lo`}, 62 bits.
  - When `hint_wide` is clear, the value is `hint_lo` zero-extended, and `hint_hi` is ignored.
- R6: A qualified value-0 hint moves the thread to PARK in the next cycle. While parked and not due, the thread loses every contested cycle.
- R7: A parked thread returns to RUN in the cycle after a store that meets two conditions. The store comes from the other thread (`st_tid`). Its address equals the thread's last loaded monitor address in bits [63:3]. A store by the parked thread itself, or to a different 8-byte block, leaves it parked.
- R8: A parked thread contesting every cycle is granted exactly once in every `FLOOR_LEN` (32) cycles. The first such grant falls 31 cycles after the cycle it entered PARK.
- R9: A qualified value-1 hint from RUN gives `BOOST_LEN` (16) cycles of BOOST, during which the thread wins every contested cycle against a RUN thread. Further value-1 hints during BOOST do not extend it.
- R10: BOOST is followed by `BOOST_LEN` cycles of COOL and then RUN. During COOL, arbitration is round-robin and value-1 hints are ignored.
- R11: A value-0 hint from BOOST or COOL moves the thread to PARK. In PARK every hint is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hint_vld | input | 2 | Per-thread hint retire strobe |
| hint_qp | input | 2 | Per-thread qualifying-predicate bit |
| hint_wide | input | 2 | Per-thread wide-form select |
| hint_lo | input | 42 | Per-thread low 21 immediate bits (thread t at [21t+20:21t]) |
| hint_hi | input | 82 | Per-thread upper 41 immediate bits, used only in wide form |
| req | input | 2 | Per-thread slot request |
| mon_ld | input | 2 | Per-thread monitor-address load strobe |
| mon_addr | input | 128 | Per-thread monitor address (thread t at [64t+63:64t]) |
| st_vld | input | 1 | Store observed on the shared bus |
| st_tid | input | 1 | Thread that issued the store |
| st_addr | input | 64 | Store address |
| gnt | output | 2 | One-hot slot grant |
| thr_state | output | 4 | Per-thread state code |

## Verification
The assertions take some things about the inputs for granted. `st_tid` names a real thread whenever `st_vld` is high, and the hint fields matter only in cycles where `hint_vld` is set. The floor check also assumes that both threads are never due in the same cycle. That is why it is limited to cycles where the other thread is not parked.

The stimulus keeps within these limits. It parks only one thread at a time and always names a valid storing thread. It loads each monitor address several cycles before the matching pause, so a load and a store never race in the same cycle.

// File: rtl/hpa_pkg.sv
package hpa_pkg;
    typedef enum logic [1:0] {
        TS_RUN   = 2'd0,
        TS_PARK  = 2'd1,
        TS_BOOST = 2'd2,
        TS_COOL  = 2'd3
    } tstate_e;

    typedef enum logic [1:0] {
        HK_NONE  = 2'd0,
        HK_PAUSE = 2'd1,
        HK_PRIO  = 2'd2
    } hkind_e;
endpackage

// File: rtl/hpa_hint_decode.sv
module hpa_hint_decode #(
    parameter int LO_W = 21,
    parameter int HI_W = 41
) (
    input  logic            vld,
    input  logic            qp,
    input  logic            wide,
    input  logic [LO_W-1:0] lo,
    input  logic [HI_W-1:0] hi,
    output hpa_pkg::hkind_e kind
);
    localparam int VAL_W = LO_W + HI_W;

    logic [VAL_W-1:0] value;

    always_comb begin
        value = wide ? {hi, lo} : {{HI_W{1'b0}}, lo};
        kind  = hpa_pkg::HK_NONE;
        if (vld && qp) begin
            if (value == VAL_W'(0))      kind = hpa_pkg::HK_PAUSE;
            else if (value == VAL_W'(1)) kind = hpa_pkg::HK_PRIO;
        end
    end
endmodule

// File: rtl/hpa_thread_fsm.sv
module hpa_thread_fsm #(
    parameter int ADDR_W    = 64,
    parameter int BOOST_LEN = 16,
    parameter int FLOOR_LEN = 32,
    parameter int TID       = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  hpa_pkg::hkind_e   kind,
    input  logic              mon_ld,
    input  logic [ADDR_W-1:0] mon_addr,
    input  logic              st_vld,
    input  logic              st_tid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic              granted,
    output hpa_pkg::tstate_e  state,
    output logic              due
);
    import hpa_pkg::*;

    localparam int BW = (BOOST_LEN > 1) ? $clog2(BOOST_LEN) : 1;
    localparam int FW = (FLOOR_LEN > 1) ? $clog2(FLOOR_LEN) : 1;
    localparam logic [BW-1:0] PHASE_LAST = BW'(BOOST_LEN - 1);
    localparam logic [FW-1:0] FLOOR_LAST = FW'(FLOOR_LEN - 1);

    tstate_e            nxt;
    logic [BW-1:0]      phase_cnt;
    logic [FW-1:0]      park_cnt;
    logic [ADDR_W-1:3]  mon_q;
    logic               wake;

    assign wake = st_vld && (st_tid != 1'(TID)) && (st_addr[ADDR_W-1:3] == mon_q);

    // next-state selection
    always_comb begin
        nxt = state;
        unique case (state)
            TS_RUN: begin
                if (kind == HK_PAUSE)     nxt = TS_PARK;
                else if (kind == HK_PRIO) nxt = TS_BOOST;
            end
            TS_PARK: begin
                if (wake) nxt = TS_RUN;
            end
            TS_BOOST: begin
                if (kind == HK_PAUSE)             nxt = TS_PARK;
                else if (phase_cnt == '0)         nxt = TS_COOL;
            end
            TS_COOL: begin
                if (kind == HK_PAUSE)             nxt = TS_PARK;
                else if (phase_cnt == '0)         nxt = TS_RUN;
            end
        endcase
    end

    // state register and counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= TS_RUN;
            phase_cnt <= '0;
            park_cnt  <= '0;
            mon_q     <= '0;
        end else begin
            state <= nxt;
            if (nxt != state && (nxt == TS_BOOST || nxt == TS_COOL))
                phase_cnt <= PHASE_LAST;
            else if (phase_cnt != '0)
                phase_cnt <= phase_cnt - 1'b1;
            if (state != TS_PARK || granted)
                park_cnt <= '0;
            else if (park_cnt != FLOOR_LAST)
                park_cnt <= park_cnt + 1'b1;
            if (mon_ld)
                mon_q <= mon_addr[ADDR_W-1:3];
        end
    end

    // outputs
    always_comb begin
        due = (state == TS_PARK) && (park_cnt == FLOOR_LAST);
    end
endmodule

// File: rtl/hpa_grant_arb.sv
module hpa_grant_arb (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       req,
    input  hpa_pkg::tstate_e st [2],
    input  logic [1:0]       due,
    output logic [1:0]       gnt
);
    import hpa_pkg::*;

    logic [1:0] rank [2];
    logic       rr_last;

    for (genvar t = 0; t < 2; t++) begin : g_rank
        always_comb begin
            if (due[t])                rank[t] = 2'd3;
            else if (st[t] == TS_BOOST) rank[t] = 2'd2;
            else if (st[t] == TS_PARK)  rank[t] = 2'd0;
            else                        rank[t] = 2'd1;
        end
    end

    always_comb begin
        unique case (req)
            2'b00: gnt = 2'b00;
            2'b01: gnt = 2'b01;
            2'b10: gnt = 2'b10;
            2'b11: begin
                if (rank[0] > rank[1])      gnt = 2'b01;
                else if (rank[1] > rank[0]) gnt = 2'b10;
                else                        gnt = rr_last ? 2'b01 : 2'b10;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)   rr_last <= 1'b1;
        else if (|gnt) rr_last <= gnt[1];
    end
endmodule

// File: rtl/hint_prio_arb.sv
module hint_prio_arb #(
    parameter int ADDR_W    = 64,
    parameter int LO_W      = 21,
    parameter int HI_W      = 41,
    parameter int BOOST_LEN = 16,
    parameter int FLOOR_LEN = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           hint_vld,
    input  logic [1:0]           hint_qp,
    input  logic [1:0]           hint_wide,
    input  logic [2*LO_W-1:0]    hint_lo,
    input  logic [2*HI_W-1:0]    hint_hi,
    input  logic [1:0]           req,
    input  logic [1:0]           mon_ld,
    input  logic [2*ADDR_W-1:0]  mon_addr,
    input  logic                 st_vld,
    input  logic                 st_tid,
    input  logic [ADDR_W-1:0]    st_addr,
    output logic [1:0]           gnt,
    output logic [3:0]           thr_state
);
    localparam int NTHR = 2;

    hpa_pkg::hkind_e  kind_w [NTHR];
    hpa_pkg::tstate_e st_w   [NTHR];
    logic [NTHR-1:0]  due_w;

    for (genvar t = 0; t < NTHR; t++) begin : g_thr
        hpa_hint_decode #(.LO_W(LO_W), .HI_W(HI_W)) u_dec (
            .vld  (hint_vld[t]),
            .qp   (hint_qp[t]),
            .wide (hint_wide[t]),
            .lo   (hint_lo[t*LO_W +: LO_W]),
            .hi   (hint_hi[t*HI_W +: HI_W]),
            .kind (kind_w[t])
        );

        hpa_thread_fsm #(
            .ADDR_W(ADDR_W), .BOOST_LEN(BOOST_LEN),
            .FLOOR_LEN(FLOOR_LEN), .TID(t)
        ) u_fsm (
            .clk      (clk),
            .rst_n    (rst_n),
            .kind     (kind_w[t]),
            .mon_ld   (mon_ld[t]),
            .mon_addr (mon_addr[t*ADDR_W +: ADDR_W]),
            .st_vld   (st_vld),
            .st_tid   (st_tid),
            .st_addr  (st_addr),
            .granted  (gnt[t]),
            .state    (st_w[t]),
            .due      (due_w[t])
        );

        assign thr_state[2*t +: 2] = st_w[t];
    end

    hpa_grant_arb u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req),
        .st    (st_w),
        .due   (due_w),
        .gnt   (gnt)
    );
endmodule

// File: rtl/hpa_chk.sv
module hpa_chk #(
    parameter int FLOOR_LEN = 32
) (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] req,
    input logic [1:0] gnt,
    input logic [3:0] thr_state,
    input logic [1:0] hint_qp
);
    localparam int CW = $clog2(FLOOR_LEN) + 1;
    localparam logic [1:0] C_RUN = 2'd0, C_PARK = 2'd1, C_BOOST = 2'd2, C_COOL = 2'd3;

    logic [CW-1:0] wait_cnt [2];

    for (genvar t = 0; t < 2; t++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (!rst_n || thr_state[2*t +: 2] != C_PARK || gnt[t])
                wait_cnt[t] <= '0;
            else if (wait_cnt[t] != CW'(FLOOR_LEN - 1))
                wait_cnt[t] <= wait_cnt[t] + 1'b1;
        end

        a_r8_floor_grant: assert property (@(posedge clk) disable iff (!rst_n)
            (thr_state[2*t +: 2] == C_PARK && req[t] &&
             thr_state[2*(1-t) +: 2] != C_PARK &&
             wait_cnt[t] == CW'(FLOOR_LEN - 1)) |-> gnt[t]);
    end

    a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt));
    a_r2_only_req: assert property (@(posedge clk) disable iff (!rst_n) (gnt & ~req) == 2'b00);
    a_r2_conserve: assert property (@(posedge clk) disable iff (!rst_n) (req != 2'b00) |-> (gnt != 2'b00));

    a_r9_boost_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (req == 2'b11 && thr_state[1:0] == C_BOOST &&
         (thr_state[3:2] == C_RUN || thr_state[3:2] == C_COOL)) |-> gnt == 2'b01);

    a_r10_boost_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_state[1:0] == C_BOOST) |=>
        (thr_state[1:0] == C_BOOST || thr_state[1:0] == C_COOL || thr_state[1:0] == C_PARK));

    a_r4_unqualified: assert property (@(posedge clk) disable iff (!rst_n)
        (!hint_qp[0] && thr_state[1:0] == C_RUN) |=> thr_state[1:0] == C_RUN);
endmodule

bind hint_prio_arb hpa_chk #(.FLOOR_LEN(FLOOR_LEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .gnt       (gnt),
    .thr_state (thr_state),
    .hint_qp   (hint_qp)
);

// File: tb/tb_hint_prio_arb.sv
module tb_hint_prio_arb;
    logic         clk = 1'b0;
    logic         rst_n;
    logic [1:0]   hint_vld, hint_qp, hint_wide;
    logic [41:0]  hint_lo;
    logic [81:0]  hint_hi;
    logic [1:0]   req, mon_ld;
    logic [127:0] mon_addr;
    logic         st_vld, st_tid;
    logic [63:0]  st_addr;
    logic [1:0]   gnt;
    logic [3:0]   thr_state;

    int n_chk = 0;
    int n_bad = 0;

    localparam logic [63:0] MADDR = 64'h1234_5678_9ABC_DEF0;

    always #5 clk = ~clk;

    hint_prio_arb dut (
        .clk(clk), .rst_n(rst_n), .hint_vld(hint_vld), .hint_qp(hint_qp),
        .hint_wide(hint_wide), .hint_lo(hint_lo), .hint_hi(hint_hi),
        .req(req), .mon_ld(mon_ld), .mon_addr(mon_addr), .st_vld(st_vld),
        .st_tid(st_tid), .st_addr(st_addr), .gnt(gnt), .thr_state(thr_state)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic clr_in();
        hint_vld = '0; hint_qp = '0; hint_wide = '0; hint_lo = '0; hint_hi = '0;
        mon_ld = '0; st_vld = 1'b0; st_tid = 1'b0; st_addr = '0;
    endtask

    task automatic put_hint(input int t, input bit wide, input logic [40:0] hi,
                            input logic [20:0] lo, input bit qp);
        hint_vld[t] = 1'b1;
        hint_qp[t] = qp;
        hint_wide[t] = wide;
        hint_hi[t*41 +: 41] = hi;
        hint_lo[t*21 +: 21] = lo;
    endtask

    // issue a hint for one cycle, leave state visible afterwards
    task automatic one_hint(input int t, input bit wide, input logic [40:0] hi,
                            input logic [20:0] lo, input bit qp);
        put_hint(t, wide, hi, lo, qp);
        tick();
        clr_in();
        #1;
    endtask

    task automatic store(input bit tid, input logic [63:0] a);
        st_vld = 1'b1; st_tid = tid; st_addr = a;
        tick();
        clr_in();
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
        $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req = '0; mon_addr = '0; clr_in();
        repeat (3) tick();
        rst_n = 1'b1;
        #1;
        chk(thr_state == 4'h0, "R1 reset state", thr_state, 0);

        // R1/R3: round-robin from thread 0
        req = 2'b11; #1;
        chk(gnt == 2'b01, "R1 first grant", gnt, 1);
        for (int i = 1; i < 9; i++) begin
            tick();
            chk(gnt == ((i % 2) ? 2'b10 : 2'b01), "R3 alternate", gnt, (i % 2) ? 2 : 1);
        end

        // R2: single requesters and idle
        req = 2'b01; #1; chk(gnt == 2'b01, "R2 only t0", gnt, 1);
        req = 2'b10; #1; chk(gnt == 2'b10, "R2 only t1", gnt, 2);
        req = 2'b00; #1; chk(gnt == 2'b00, "R2 idle", gnt, 0);

        // R4: reserved values and unqualified hints leave state alone
        for (int v = 2; v < 64; v++) begin
            one_hint(0, 1'b0, '0, 21'(v), 1'b1);
            chk(thr_state == 4'h0, "R4 reserved value", thr_state, 0);
        end
        one_hint(0, 1'b0, '0, 21'h1FFFFF, 1'b1);
        chk(thr_state == 4'h0, "R4 large value", thr_state, 0);
        one_hint(0, 1'b0, '0, 21'd0, 1'b0);
        chk(thr_state == 4'h0, "R4 unqualified pause", thr_state, 0);
        one_hint(1, 1'b0, '0, 21'd1, 1'b0);
        chk(thr_state == 4'h0, "R4 unqualified prio", thr_state, 0);

        // R5: wide form with upper bits set is no pause/prio
        one_hint(0, 1'b1, 41'd1, 21'd1, 1'b1);
        chk(thr_state == 4'h0, "R5 wide nonzero upper", thr_state, 0);
        one_hint(1, 1'b1, 41'd4, 21'd0, 1'b1);
        chk(thr_state == 4'h0, "R5 wide upper only", thr_state, 0);

        // load monitor address for thread 1
        mon_ld[1] = 1'b1; mon_addr[127:64] = MADDR;
        tick(); clr_in();

        // R5/R6: narrow form ignores upper bits -> pause on thread 1
        put_hint(1, 1'b0, {41{1'b1}}, 21'd0, 1'b1);
        tick(); clr_in();
        req = 2'b11; #1;
        chk(thr_state[3:2] == 2'd1, "R5 narrow pause", thr_state, 4);

        // R6/R8: floor grant every 32 cycles
        for (int i = 0; i < 64; i++) begin
            logic [1:0] e;
            e = (i == 31 || i == 63) ? 2'b10 : 2'b01;
            chk(gnt == e, (i % 32 == 31) ? "R8 floor grant" : "R6 parked loses", gnt, e);
            tick();
        end

        // R7: non-waking stores
        store(1'b1, MADDR);
        chk(thr_state[3:2] == 2'd1, "R7 own store", thr_state, 4);
        store(1'b0, MADDR ^ 64'h40);
        chk(thr_state[3:2] == 2'd1, "R7 other block", thr_state, 4);
        // R11: hints ignored while parked
        one_hint(1, 1'b0, '0, 21'd1, 1'b1);
        chk(thr_state[3:2] == 2'd1, "R11 prio while parked", thr_state, 4);
        // R7: waking store, low 3 bits differ
        store(1'b0, MADDR | 64'h5);
        chk(thr_state[3:2] == 2'd0, "R7 wake", thr_state, 0);

        // R9: boost on thread 0
        one_hint(0, 1'b0, '0, 21'd1, 1'b1);
        for (int i = 0; i < 16; i++) begin
            chk(thr_state[1:0] == 2'd2, "R9 boost state", thr_state, 2);
            chk(gnt == 2'b01, "R9 boost wins", gnt, 1);
            if (i == 5) put_hint(0, 1'b0, '0, 21'd1, 1'b1);
            tick();
            clr_in();
            #1;
        end

        // R10: cooldown, round-robin, prio ignored
        for (int j = 0; j < 16; j++) begin
            logic [1:0] e;
            e = (j % 2 == 0) ? 2'b10 : 2'b01;
            chk(thr_state[1:0] == 2'd3, "R10 cooldown state", thr_state, 3);
            chk(gnt == e, "R10 cooldown rr", gnt, e);
            if (j == 3) put_hint(0, 1'b0, '0, 21'd1, 1'b1);
            tick();
            clr_in();
            #1;
        end
        chk(thr_state[1:0] == 2'd0, "R10 back to run", thr_state, 0);

        // R11: pause from boost
        one_hint(1, 1'b0, '0, 21'd1, 1'b1);
        chk(thr_state[3:2] == 2'd2, "R11 t1 boosted", thr_state, 8);
        one_hint(1, 1'b0, '0, 21'd0, 1'b1);
        chk(thr_state[3:2] == 2'd1, "R11 boost to park", thr_state, 4);
        store(1'b0, MADDR);
        chk(thr_state[3:2] == 2'd0, "R7 wake again", thr_state, 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule